// File: doc/BRIEF.md
# Multi-Channel Clock Frequency Supervisor

This block watches six clocks from a single reference clock domain. It counts the rising edges of each watched clock over a fixed number of reference cycles. At the end of every such window it sorts the count into one of three bands: a nominal band, a warning band on either side of it, and an error band outside the warning band. Each channel can therefore show a drifting clock early and a failed clock firmly. It also shows whether the clock runs too fast or too slow.

Channel 2 works the other way round. Its count comes from an alternate clock source, so the count measures the reference clock itself. A high count of the alternate clock means the reference is slow, and the direction flags of channel 2 are swapped to match.

Software controls the block through a six-bit enable register and reads two sticky status bytes that are cleared by writing one. A self-test strobe replaces the count of every enabled channel with zero for one window, so the detection path can be proven without stopping any clock.

Top module: `freq_guard`

## Requirements
- R1: After reset, `en_q` is 6'b111110, so channel 1 is off and channels 2 to 6 are on (bit i of every six-bit vector is channel i+1). `err_stat`, `warn_stat`, `fast_flag` and `slow_flag` are all zero.
- R2: When `ctrl_we` is high at a rising edge, `en_q` takes `ctrl_wdata` at that edge.
- R3: Each enabled channel counts the edges of its watched clock over WINDOW reference cycles. A count below its ERR_LO sets its error bit and raises `slow_flag`. A count above its ERR_HI sets its error bit and raises `fast_flag`. The two flags are never high together.
- R4: A count below WARN_LO or above WARN_HI sets the channel's warning bit. The error limits lie outside the warning limits, so whenever an error bit rises, the warning bit is already set or rises with it. Channel 2 has no warning bit.
- R5: The status bit positions are fixed. Channel 1 uses bit 2, channel 2 bit 0, channel 3 bit 3, channel 4 bit 4, channel 5 bit 6 and channel 6 bit 1. `warn_stat` uses the same positions, but bit 0 is always 0. Bits 5 and 7 of both bytes always read 0.
- R6: Channel 2 counts edges of the alternate source on `mon_clk[1]`. A count above its ERR_HI raises `slow_flag[1]`, and a count below its ERR_LO raises `fast_flag[1]`.
- R7: Status bits are sticky. A one in `err_clr` or `warn_clr` clears the matching bit on the next edge, unless a new event for that bit arrives in the same cycle; in that case the bit stays set.
- R8: A disabled channel clears its counter, its flags and its status bits, and it records no event. After the channel is enabled again, its first window is discarded, so a correct clock raises no error.
- R9: Monitoring repeats every window while the channel is enabled. The flags show the result of the most recent complete window.
- R10: With the default parameters, a step of a watched clock into the error band sets the error bit within 143 reference cycles.
- R11: A one-cycle pulse on `bist_force` sets the error and warning bits of every enabled channel within 143 reference cycles, because their counts are replaced with zero for one window. Disabled channels are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for all counting and registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| mon_clk | input | 6 | Watched clocks; bit 1 carries the alternate source for channel 2 |
| ctrl_we | input | 1 | Write strobe for the enable register |
| ctrl_wdata | input | 6 | New enable value |
| en_q | output | 6 | Current enable register |
| err_clr | input | 8 | Write-one-to-clear mask for `err_stat` |
| warn_clr | input | 8 | Write-one-to-clear mask for `warn_stat` |
| bist_force | input | 1 | Self-test strobe |
| err_stat | output | 8 | Sticky error bits |
| warn_stat | output | 8 | Sticky warning bits |
| fast_flag | output | 6 | Error-band over-frequency result of the latest window |
| slow_flag | output | 6 | Error-band under-frequency result of the latest window |

## Verification
Faults inside the block appear at the ports in a few recognisable ways:
- A corrupted window counter or edge counter shifts the band a channel lands in. A nominal clock then reports a warning, or a clock in the error band is missed, and this shows at the end of the next window.
- A wrong position map moves a fault into another channel's status bit.
- A lost swap on channel 2 inverts its direction flags.
- A broken first-window discard produces a spurious error within one window of re-enabling a channel.

The longest any of these stays hidden is two windows plus the synchroniser depth.

// File: rtl/freq_guard_pkg.sv
package freq_guard_pkg;

  localparam int unsigned NCH = 6;

  typedef struct packed {
    logic err_fast;
    logic err_slow;
    logic wrn_fast;
    logic wrn_slow;
  } band_t;

  // status byte position of a channel (index 0 = channel 1)
  function automatic logic [2:0] stat_pos(input int unsigned ch);
    case (ch)
      0:       return 3'd2;
      1:       return 3'd0;
      2:       return 3'd3;
      3:       return 3'd4;
      4:       return 3'd6;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic has_warn(input int unsigned ch);
    return ch != 1;
  endfunction

  // sorts a window count into bands; swap flips the meaning of direction
  function automatic band_t classify(input int unsigned cnt,
                                     input int unsigned e_lo,
                                     input int unsigned w_lo,
                                     input int unsigned w_hi,
                                     input int unsigned e_hi,
                                     input logic swap);
    band_t r;
    logic  below_e, below_w, above_w, above_e;
    below_e = cnt < e_lo;
    below_w = cnt < w_lo;
    above_w = cnt > w_hi;
    above_e = cnt > e_hi;
    if (swap) begin
      r.err_fast = below_e;
      r.err_slow = above_e;
      r.wrn_fast = below_w;
      r.wrn_slow = above_w;
    end else begin
      r.err_fast = above_e;
      r.err_slow = below_e;
      r.wrn_fast = above_w;
      r.wrn_slow = below_w;
    end
    return r;
  endfunction

endpackage

// File: rtl/freq_guard_tsync.sv
module freq_guard_tsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic src_clk,
  input  logic dst_clk,
  input  logic rst_n,
  output logic edge_pulse
);
  logic              tgl;
  logic [STAGES:0]   sh;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) tgl <= 1'b0;
    else        tgl <= ~tgl;
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], tgl};
  end

  assign edge_pulse = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/freq_guard_win.sv
module freq_guard_win #(
  parameter int unsigned WINDOW = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bist_force,
  output logic wnd_end,
  output logic force_zero
);
  localparam int unsigned WW = (WINDOW > 1) ? $clog2(WINDOW) : 1;

  logic [WW-1:0] wcnt;
  logic          pend;

  assign wnd_end = (wcnt == WW'(WINDOW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt       <= '0;
      pend       <= 1'b0;
      force_zero <= 1'b0;
    end else begin
      wcnt <= wnd_end ? '0 : wcnt + 1'b1;
      if (wnd_end) begin
        force_zero <= pend | bist_force;
        pend       <= 1'b0;
      end else if (bist_force) begin
        pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/freq_guard_chan.sv
module freq_guard_chan import freq_guard_pkg::*; #(
  parameter int unsigned CW       = 8,
  parameter int unsigned LIM_ELO  = 11,
  parameter int unsigned LIM_WLO  = 14,
  parameter int unsigned LIM_WHI  = 18,
  parameter int unsigned LIM_EHI  = 21,
  parameter bit          SWAP     = 1'b0,
  parameter bit          HAS_WARN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic edge_pulse,
  input  logic wnd_end,
  input  logic force_zero,
  output logic evt_err,
  output logic evt_wrn,
  output logic fast_q,
  output logic slow_q
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_inc;
  logic          armed;
  band_t         bnd;

  assign cnt_inc = (edge_pulse && (cnt != {CW{1'b1}})) ? cnt + 1'b1 : cnt;
  assign bnd     = classify(force_zero ? 32'd0 : 32'(cnt_inc),
                            LIM_ELO, LIM_WLO, LIM_WHI, LIM_EHI, SWAP);

  assign evt_err = en && armed && wnd_end && (bnd.err_fast || bnd.err_slow);
  assign evt_wrn = HAS_WARN && en && armed && wnd_end && (bnd.wrn_fast || bnd.wrn_slow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      armed  <= 1'b0;
      fast_q <= 1'b0;
      slow_q <= 1'b0;
    end else if (!en) begin
      cnt    <= '0;
      armed  <= 1'b0;
      fast_q <= 1'b0;
      slow_q <= 1'b0;
    end else if (wnd_end) begin
      cnt   <= '0;
      armed <= 1'b1;
      if (armed) begin
        fast_q <= bnd.err_fast;
        slow_q <= bnd.err_slow;
      end
    end else begin
      cnt <= cnt_inc;
    end
  end
endmodule

// File: rtl/freq_guard.sv
module freq_guard import freq_guard_pkg::*; #(
  parameter int unsigned     WINDOW      = 64,
  parameter int unsigned     CW          = 8,
  parameter int unsigned     SYNC_STAGES = 2,
  parameter logic [NCH-1:0]  EN_RESET    = 6'b111110,
  parameter int unsigned     ERR_LO  [NCH] = '{11, 11, 11, 11, 11, 11},
  parameter int unsigned     WARN_LO [NCH] = '{14, 14, 14, 14, 14, 14},
  parameter int unsigned     WARN_HI [NCH] = '{18, 18, 18, 18, 18, 18},
  parameter int unsigned     ERR_HI  [NCH] = '{21, 21, 21, 21, 21, 21}
) (
  input  logic           ref_clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] mon_clk,
  input  logic           ctrl_we,
  input  logic [NCH-1:0] ctrl_wdata,
  output logic [NCH-1:0] en_q,
  input  logic [7:0]     err_clr,
  input  logic [7:0]     warn_clr,
  input  logic           bist_force,
  output logic [7:0]     err_stat,
  output logic [7:0]     warn_stat,
  output logic [NCH-1:0] fast_flag,
  output logic [NCH-1:0] slow_flag
);
  logic           wnd_end;
  logic           force_zero;
  logic [NCH-1:0] edge_seen;
  logic [NCH-1:0] ch_err_evt;
  logic [NCH-1:0] ch_wrn_evt;
  logic [7:0]     err_set, wrn_set, err_keep, wrn_keep;

  freq_guard_win #(.WINDOW(WINDOW)) u_win (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .bist_force (bist_force),
    .wnd_end    (wnd_end),
    .force_zero (force_zero)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    freq_guard_tsync #(.STAGES(SYNC_STAGES)) u_sync (
      .src_clk    (mon_clk[g]),
      .dst_clk    (ref_clk),
      .rst_n      (rst_n),
      .edge_pulse (edge_seen[g])
    );

    freq_guard_chan #(
      .CW       (CW),
      .LIM_ELO  (ERR_LO[g]),
      .LIM_WLO  (WARN_LO[g]),
      .LIM_WHI  (WARN_HI[g]),
      .LIM_EHI  (ERR_HI[g]),
      .SWAP     (g == 1),
      .HAS_WARN (has_warn(g))
    ) u_chan (
      .clk        (ref_clk),
      .rst_n      (rst_n),
      .en         (en_q[g]),
      .edge_pulse (edge_seen[g]),
      .wnd_end    (wnd_end),
      .force_zero (force_zero),
      .evt_err    (ch_err_evt[g]),
      .evt_wrn    (ch_wrn_evt[g]),
      .fast_q     (fast_flag[g]),
      .slow_q     (slow_flag[g])
    );
  end

  always_comb begin
    err_set  = '0;
    wrn_set  = '0;
    err_keep = '0;
    wrn_keep = '0;
    for (int i = 0; i < NCH; i++) begin
      err_set[stat_pos(i)]  = ch_err_evt[i];
      err_keep[stat_pos(i)] = en_q[i];
      if (has_warn(i)) begin
        wrn_set[stat_pos(i)]  = ch_wrn_evt[i];
        wrn_keep[stat_pos(i)] = en_q[i];
      end
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= EN_RESET;
      err_stat  <= '0;
      warn_stat <= '0;
    end else begin
      if (ctrl_we) en_q <= ctrl_wdata;
      err_stat  <= ((err_stat  & ~err_clr)  | err_set) & err_keep;
      warn_stat <= ((warn_stat & ~warn_clr) | wrn_set) & wrn_keep;
    end
  end
endmodule

// File: rtl/freq_guard_chk.sv
module freq_guard_chk import freq_guard_pkg::*; (
  input logic           ref_clk,
  input logic           rst_n,
  input logic           ctrl_we,
  input logic [NCH-1:0] ctrl_wdata,
  input logic [NCH-1:0] en_q,
  input logic [7:0]     err_clr,
  input logic [7:0]     warn_clr,
  input logic [7:0]     err_stat,
  input logic [7:0]     warn_stat,
  input logic [NCH-1:0] fast_flag,
  input logic [NCH-1:0] slow_flag,
  input logic [NCH-1:0] ch_err_evt,
  input logic [NCH-1:0] ch_wrn_evt
);
  logic unused_bits;
  assign unused_bits = ^{err_clr[7], err_clr[5], warn_clr[7], warn_clr[5],
                         err_stat[7], err_stat[5], warn_stat[7], warn_stat[5]};

  assert_enable_write_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ctrl_we |=> (en_q == $past(ctrl_wdata)));

  for (genvar g = 0; g < NCH; g++) begin : g_a
    localparam logic [2:0] P = stat_pos(g);

    assert_one_direction_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !(fast_flag[g] && slow_flag[g]));

    assert_event_sets_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      ch_err_evt[g] |=> err_stat[P]);

    assert_w1c_err_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (err_stat[P] && err_clr[P] && !ch_err_evt[g]) |=> !err_stat[P]);

    assert_w1c_warn_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (warn_stat[P] && warn_clr[P] && !ch_wrn_evt[g]) |=> !warn_stat[P]);

    assert_sticky_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (err_stat[P] && !err_clr[P] && en_q[g] && !(ctrl_we && !ctrl_wdata[g]))
        |=> err_stat[P]);

    assert_off_no_flag_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !en_q[g] |=> (!fast_flag[g] && !slow_flag[g]));

    assert_rise_needs_en_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(err_stat[P]) |-> $past(en_q[g]));

    if (g != 1) begin : g_w
      assert_err_with_warn_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(err_stat[P]) |-> warn_stat[P]);
    end
  end
endmodule

bind freq_guard freq_guard_chk u_chk (
  .ref_clk    (ref_clk),
  .rst_n      (rst_n),
  .ctrl_we    (ctrl_we),
  .ctrl_wdata (ctrl_wdata),
  .en_q       (en_q),
  .err_clr    (err_clr),
  .warn_clr   (warn_clr),
  .err_stat   (err_stat),
  .warn_stat  (warn_stat),
  .fast_flag  (fast_flag),
  .slow_flag  (slow_flag),
  .ch_err_evt (ch_err_evt),
  .ch_wrn_evt (ch_wrn_evt)
);

// File: tb/sim_freq_guard.sv
`timescale 1ns/1ps
module sim_freq_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] mclk;
  logic       ctrl_we = 1'b0;
  logic [5:0] ctrl_wdata = '0;
  logic [5:0] en_q;
  logic [7:0] err_clr = '0, warn_clr = '0;
  logic       bist_force = 1'b0;
  logic [7:0] err_stat, warn_stat;
  logic [5:0] fast_flag, slow_flag;

  int  total = 0, bad = 0;
  bit  done = 0;
  real mper [6];
  // band classes: 0 nominal, 1 warn slow, 2 err slow, 3 warn fast, 4 err fast
  real CLS_PER [5] = '{32.0, 40.0, 56.0, 26.0, 20.0};
  int  BPOS [6] = '{2, 0, 3, 4, 6, 1};

  always #4 clk = ~clk;

  for (genvar g = 0; g < 6; g++) begin : g_mc
    logic mc = 1'b0;
    initial forever #(mper[g] / 2.0) mc = ~mc;
    assign mclk[g] = mc;
  end

  freq_guard u0 (
    .ref_clk(clk), .rst_n(rst_n), .mon_clk(mclk),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .en_q(en_q),
    .err_clr(err_clr), .warn_clr(warn_clr), .bist_force(bist_force),
    .err_stat(err_stat), .warn_stat(warn_stat),
    .fast_flag(fast_flag), .slow_flag(slow_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_en(input logic [5:0] m);
    ctrl_wdata = m; ctrl_we = 1'b1; tick(1); ctrl_we = 1'b0;
  endtask

  task automatic clr(input logic [7:0] e, input logic [7:0] w);
    err_clr = e; warn_clr = w; tick(1); err_clr = '0; warn_clr = '0;
  endtask

  function automatic int exp_err(input int k);
    return (k == 2 || k == 4) ? 1 : 0;
  endfunction

  function automatic int exp_fast(input int c, input int k);
    return (c == 1) ? int'(k == 2) : int'(k == 4);
  endfunction

  function automatic int exp_slow(input int c, input int k);
    return (c == 1) ? int'(k == 4) : int'(k == 2);
  endfunction

  task automatic run_trial();
    int         cls [6];
    logic [5:0] msk;
    for (int c = 0; c < 6; c++) begin
      cls[c]  = $urandom_range(0, 4);
      mper[c] = CLS_PER[cls[c]];
    end
    msk = 6'($urandom_range(0, 63));
    wr_en(msk);
    tick(160);
    clr(8'hFF, 8'hFF);
    tick(200);
    for (int c = 0; c < 6; c++) begin
      int on = int'(msk[c]);
      chk(on ? "R3 error bit" : "R8 disabled error bit", int'(err_stat[BPOS[c]]), on * exp_err(cls[c]));
      if (c != 1)
        chk(on ? "R4 warning bit" : "R8 disabled warning bit", int'(warn_stat[BPOS[c]]),
            on * int'(cls[c] != 0));
      chk(c == 1 ? "R6 swapped fast flag" : "R9 fast flag", int'(fast_flag[c]), on * exp_fast(c, cls[c]));
      chk(c == 1 ? "R6 swapped slow flag" : "R9 slow flag", int'(slow_flag[c]), on * exp_slow(c, cls[c]));
    end
    chk("R5 spare error bits", int'({err_stat[7], err_stat[5]}), 0);
    chk("R5 spare warning bits", int'({warn_stat[7], warn_stat[5], warn_stat[0]}), 0);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int lat;
    void'($urandom(32'd20231));
    for (int c = 0; c < 6; c++) mper[c] = 32.0;
    tick(5);
    rst_n = 1'b1;
    tick(1);
    chk("R1 reset enables", int'(en_q), 6'b111110);
    chk("R1 reset errors", int'(err_stat), 0);
    chk("R1 reset warnings", int'(warn_stat), 0);
    chk("R1 reset flags", int'({fast_flag, slow_flag}), 0);

    wr_en(6'b101101);
    chk("R2 enable write", int'(en_q), 6'b101101);

    for (int t = 0; t < 20; t++) run_trial();

    // disabled channel with a bad clock stays silent
    for (int c = 0; c < 6; c++) mper[c] = 32.0;
    mper[2] = 20.0;
    wr_en(6'b111011);
    tick(200);
    chk("R8 off channel error", int'(err_stat[3]), 0);
    chk("R8 off channel warning", int'(warn_stat[3]), 0);
    chk("R8 off channel flag", int'(fast_flag[2]), 0);

    // re-enable with a good clock: no false error from the partial window
    mper[2] = 32.0;
    wr_en(6'b110111);
    tick(150);
    wr_en(6'b111111);
    tick(200);
    chk("R8 re-enable error", int'(err_stat[4]), 0);
    chk("R8 re-enable warning", int'(warn_stat[4]), 0);

    // detection latency
    tick(160);
    clr(8'hFF, 8'hFF);
    tick(5);
    chk("R10 clean before step", int'(err_stat[3]), 0);
    mper[2] = 20.0;
    lat = 0;
    while (!err_stat[3] && lat < 300) begin tick(1); lat++; end
    chk("R10 latency within 143", int'(lat <= 143), 1);
    mper[2] = 32.0;

    // self-test strobe
    tick(160);
    wr_en(6'b111110);
    tick(5);
    clr(8'hFF, 8'hFF);
    bist_force = 1'b1; tick(1); bist_force = 1'b0;
    tick(140);
    chk("R11 self-test errors", int'(err_stat), 8'h5B);
    chk("R11 self-test warnings", int'(warn_stat), 8'h5A);

    // write-one-to-clear on single bits
    clr(8'h08, 8'h00);
    chk("R7 clear one error bit", int'(err_stat), 8'h53);
    chk("R7 warnings untouched", int'(warn_stat), 8'h5A);
    clr(8'h00, 8'h02);
    chk("R7 clear one warning bit", int'(warn_stat), 8'h58);
    chk("R7 errors untouched", int'(err_stat), 8'h53);

    done = 1;
    summary();
    $finish;
  end
endmodule